// File: doc/BRIEF.md
# Dual-Bank Flash Operation Status Unit

This unit covers the control and status side of a NOR flash array split into two banks. It tracks a single embedded program or erase at a time. That operation is confined to one bank, and the bank is chosen by comparing the operation address with a parameterised boundary. A read aimed at the other bank passes the array's data straight through in the same cycle, with no added wait. A read aimed at the bank that is working returns a status word instead of data.

The status word carries two flags. The top bit is a data-polling bit: it holds the inverse of the programmed value's top bit during a program, and 0 during an erase. The next bit is a toggle bit that flips on each read of the working bank. A ready output is low while an operation runs. An erase can be paused and later continued. When the internal completion strobe arrives, the working bank returns to plain reads without any further command.

Top module: `flash_bank_status`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), ready is 1 and reads of either bank return array_rdata unchanged.
- R2: An address below BANK_SPLIT belongs to bank 0 and any other address to bank 1. While an operation runs, a read of the other bank returns array_rdata in the same cycle.
- R3: A start strobe accepted while no operation is open makes ready 0 from the next cycle until completion.
- R4: A read of the working bank returns a status word. Bit DATA_W-1 is the inverse of bit DATA_W-1 of op_wdata for a program (op_erase=0) and 0 for an erase (op_erase=1). Bits DATA_W-3..0 read 0.
- R5: While the operation runs, status bit DATA_W-2 takes the opposite value on each successive read of the working bank.
- R6: A done strobe while running makes ready 1 on the next cycle, and reads of the former working bank then return array_rdata.
- R7: A suspend strobe during a running erase makes ready 1 from the next cycle. Reads of the working bank still return status, with bit DATA_W-2 frozen. A suspend during a program is ignored.
- R8: A resume strobe while suspended makes ready 0 again from the next cycle, and bit DATA_W-2 resumes flipping on reads.
- R9: A start strobe while an operation is running or suspended is ignored: the polling bit and the working bank stay as they were, and a single done strobe still ends the operation.
- R10: A done strobe while suspended is ignored.
- R11: When done and a read of the working bank occur in the same cycle, that read returns the status word, and a read in the next cycle returns array data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Operation request strobe |
| op_erase | input | 1 | 1 = erase, 0 = program |
| op_addr | input | ADDR_W | Operation address, selects the bank |
| op_wdata | input | DATA_W | Data being programmed |
| done | input | 1 | Internal completion strobe |
| suspend | input | 1 | Erase pause strobe |
| resume | input | 1 | Erase continue strobe |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| array_rdata | input | DATA_W | Data from the cell array |
| rd_data | output | DATA_W | Read result: array data or status |
| ready | output | 1 | 1 = no operation in progress |

## Verification
Two functions can land in the same cycle: completion of the operation and a status read of the working bank. The bench raises done and rd_en on the working bank's address in one cycle. It expects the status word (polling bit still inverted) in that cycle and array data in the next cycle. The same kind of collision is also provoked for a start strobe against a running operation, for done against a suspended erase, and for reads on either side of the bank boundary while the upper bank is working.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_SUSP = 2'd2
  } op_state_t;

  // Bank index of an address: 0 below the split, 1 at or above it.
  function automatic logic bank_of(input logic [31:0] addr, input logic [31:0] split);
    return (addr >= split);
  endfunction

  // Polling bit captured at start: inverse of data MSB for program, 0 for erase.
  function automatic logic poll_of(input logic is_erase, input logic data_msb);
    return is_erase ? 1'b0 : ~data_msb;
  endfunction
endpackage

// File: rtl/op_tracker.sv
module op_tracker
  import flash_stat_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_ok,
  input  logic      op_erase,
  input  logic      op_bank,
  input  logic      poll_in,
  input  logic      done,
  input  logic      suspend,
  input  logic      resume,
  output op_state_t state,
  output logic      run_bank,
  output logic      run_erase,
  output logic      poll_bit
);
  op_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start_ok) nxt = ST_RUN;
      ST_RUN: begin
        if (done) nxt = ST_IDLE;
        else if (suspend && run_erase) nxt = ST_SUSP;
      end
      ST_SUSP: if (resume) nxt = ST_RUN;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      run_bank  <= 1'b0;
      run_erase <= 1'b0;
      poll_bit  <= 1'b0;
    end else begin
      state <= nxt;
      if (start_ok) begin
        run_bank  <= op_bank;
        run_erase <= op_erase;
        poll_bit  <= poll_in;
      end
    end
  end
endmodule

// File: rtl/toggle_gen.sv
module toggle_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic flip,
  output logic tog
);
  always_ff @(posedge clk) begin
    if (!rst_n) tog <= 1'b0;
    else if (flip) tog <= ~tog;
  end
endmodule

// File: rtl/read_router.sv
module read_router #(
  parameter int DATA_W = 8
) (
  input  logic              busy_hit,
  input  logic              poll_bit,
  input  logic              tog,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data
);
  localparam int LOW_W = DATA_W - 2;
  logic [DATA_W-1:0] status_word;

  assign status_word = {poll_bit, tog, {LOW_W{1'b0}}};
  assign rd_data     = busy_hit ? status_word : array_rdata;
endmodule

// File: rtl/flash_bank_status.sv
module flash_bank_status
  import flash_stat_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int BANK_SPLIT = 16'h4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_erase,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  input  logic              done,
  input  logic              suspend,
  input  logic              resume,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] array_rdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              ready
);
  localparam logic [31:0] SPLIT32 = 32'(BANK_SPLIT);

  op_state_t state;
  logic run_bank, run_erase, poll_bit, tog;
  logic start_ok, done_ok, busy_hit, flip_req, op_bank, rd_bank, poll_in;

  assign op_bank  = bank_of(32'(op_addr), SPLIT32);
  assign rd_bank  = bank_of(32'(rd_addr), SPLIT32);
  assign poll_in  = poll_of(op_erase, op_wdata[DATA_W-1]);
  assign start_ok = start && (state == ST_IDLE);
  assign done_ok  = done && (state == ST_RUN);
  assign busy_hit = rd_en && (state != ST_IDLE) && (rd_bank == run_bank);
  assign flip_req = busy_hit && (state == ST_RUN);
  assign ready    = (state != ST_RUN);

  op_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .op_erase(op_erase),
    .op_bank(op_bank), .poll_in(poll_in), .done(done), .suspend(suspend),
    .resume(resume), .state(state), .run_bank(run_bank),
    .run_erase(run_erase), .poll_bit(poll_bit)
  );

  toggle_gen u_tog (.clk(clk), .rst_n(rst_n), .flip(flip_req), .tog(tog));

  read_router #(.DATA_W(DATA_W)) u_rt (
    .busy_hit(busy_hit), .poll_bit(poll_bit), .tog(tog),
    .array_rdata(array_rdata), .rd_data(rd_data)
  );
endmodule

// File: rtl/flash_bank_status_chk.sv
module flash_bank_status_chk
  import flash_stat_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_ok,
  input logic              start,
  input logic              done_ok,
  input logic              busy_hit,
  input logic              rd_en,
  input logic              tog,
  input logic              ready,
  input logic              run_bank,
  input logic              poll_bit,
  input op_state_t         state,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] array_rdata
);
  assert_start_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |=> !ready);
  assert_done_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> ready);
  assert_toggle_flip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_hit && state == ST_RUN) |=> (tog != $past(tog)));
  assert_susp_freeze_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SUSP) |=> $stable(tog));
  assert_idle_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !busy_hit) |-> (rd_data == array_rdata));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state != ST_IDLE) |=> ($stable(run_bank) && $stable(poll_bit)));
endmodule

bind flash_bank_status flash_bank_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .start(start),
  .done_ok(done_ok), .busy_hit(busy_hit), .rd_en(rd_en), .tog(tog),
  .ready(ready), .run_bank(run_bank), .poll_bit(poll_bit), .state(state),
  .rd_data(rd_data), .array_rdata(array_rdata)
);

// File: tb/sim_flash_bank_status.sv
`timescale 1ns/1ps
module sim_flash_bank_status;
  logic clk = 0, rst_n = 0;
  logic start = 0, op_erase = 0, done = 0, suspend = 0, resume = 0, rd_en = 0;
  logic [15:0] op_addr = 0, rd_addr = 0;
  logic [7:0]  op_wdata = 0, array_rdata, rd_data;
  logic ready;
  int checks = 0, errors = 0;
  logic [7:0] got;
  logic got_rdy;

  always #4 clk = ~clk;

  function automatic logic [7:0] arr(input logic [15:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction
  assign array_rdata = arr(rd_addr);

  flash_bank_status u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase),
    .op_addr(op_addr), .op_wdata(op_wdata), .done(done), .suspend(suspend),
    .resume(resume), .rd_en(rd_en), .rd_addr(rd_addr),
    .array_rdata(array_rdata), .rd_data(rd_data), .ready(ready)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, sample shortly after.
  task automatic step(input logic s, input logic e, input logic d, input logic su,
                      input logic re, input logic r, input logic [15:0] a,
                      input logic [7:0] wd);
    @(negedge clk);
    start = s; op_erase = e; done = d; suspend = su; resume = re; rd_en = r;
    op_addr = a; rd_addr = a; op_wdata = wd;
    #1;
    got = rd_data; got_rdy = ready;
  endtask

  task automatic idle(); step(0,0,0,0,0,0,16'h0,8'h0); endtask
  task automatic rd(input logic [15:0] a); step(0,0,0,0,0,1,a,8'h0); endtask

  task automatic t_reset();
    rst_n = 0; idle(); idle(); rst_n = 1;
    rd(16'h0012); chk("R1 ready", {7'b0,got_rdy}, 8'h01); chk("R1 bank0", got, arr(16'h0012));
    rd(16'h7001); chk("R1 bank1", got, arr(16'h7001));
  endtask

  task automatic t_program();
    logic t0;
    step(1,0,0,0,0,0,16'h5000,8'h3C);
    idle(); chk("R3 busy", {7'b0,got_rdy}, 8'h00);
    rd(16'h0010); chk("R2 other bank", got, arr(16'h0010));
    rd(16'h3FFF); chk("R2 boundary low", got, arr(16'h3FFF));
    rd(16'h4000); t0 = got[6]; chk("R4 program status", got, {1'b1, t0, 6'b0});
    rd(16'h5000); chk("R5 toggle", got, {1'b1, ~t0, 6'b0});
    step(0,0,0,1,0,0,16'h0,8'h0); idle();
    chk("R7 suspend on program ignored", {7'b0,got_rdy}, 8'h00);
    step(1,1,0,0,0,0,16'h5000,8'hFF); // R9 start while running
    rd(16'h5000); chk("R9 poll kept", {7'b0,got[7]}, 8'h01);
    rd(16'h0020); chk("R9 bank kept", got, arr(16'h0020));
    step(0,0,1,0,0,0,16'h0,8'h0);
    idle(); chk("R6 ready", {7'b0,got_rdy}, 8'h01);
    rd(16'h5000); chk("R6 read mode", got, arr(16'h5000));
    idle(); chk("R9 no second op", {7'b0,got_rdy}, 8'h01);
  endtask

  task automatic t_erase();
    logic t0;
    step(1,1,0,0,0,0,16'h0100,8'h00);
    rd(16'h0100); t0 = got[6]; chk("R4 erase status", got, {1'b0, t0, 6'b0});
    rd(16'h6000); chk("R2 bank1 while bank0 busy", got, arr(16'h6000));
    step(0,0,0,1,0,0,16'h0,8'h0);
    idle(); chk("R7 ready in suspend", {7'b0,got_rdy}, 8'h01);
    rd(16'h0100); chk("R7 frozen 1", got, {1'b0, ~t0, 6'b0});
    rd(16'h0100); chk("R7 frozen 2", got, {1'b0, ~t0, 6'b0});
    step(0,0,1,0,0,0,16'h0,8'h0);
    rd(16'h0100); chk("R10 done in suspend ignored", got, {1'b0, ~t0, 6'b0});
    step(1,0,0,0,0,0,16'h0200,8'h00);
    idle(); chk("R9 start in suspend ignored", {7'b0,got_rdy}, 8'h01);
    step(0,0,0,0,1,0,16'h0,8'h0);
    idle(); chk("R8 busy after resume", {7'b0,got_rdy}, 8'h00);
    rd(16'h0100); chk("R8 toggle a", got, {1'b0, ~t0, 6'b0});
    rd(16'h0100); chk("R8 toggle b", got, {1'b0, t0, 6'b0});
    step(0,0,1,0,0,0,16'h0,8'h0);
    rd(16'h0100); chk("R6 erase read mode", got, arr(16'h0100));
  endtask

  task automatic t_collide();
    step(1,0,0,0,0,0,16'h0300,8'h00);
    step(0,0,1,0,0,1,16'h0300,8'h00);
    chk("R11 same-cycle status", {7'b0,got[7]}, 8'h01);
    chk("R11 low bits", {2'b0,got[5:0]}, 8'h00);
    rd(16'h0300); chk("R11 next cycle data", got, arr(16'h0300));
  endtask

  initial begin
    fork
      begin
        t_reset(); t_program(); t_erase(); t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual timeout expected finish");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule